// File: doc/BRIEF.md
# FP32 Fraction Reduction Unit

The unit accepts one IEEE-754 single-precision operand and an 8-bit control byte. It scales the operand by 2^M and rounds it to an integer under a selectable rounding mode. It then takes that rounded value, scaled back by 2^-M, away from the operand. The output is the part of the operand that lies below the M-th fraction bit, re-encoded as a normalized or subnormal single-precision number. Invalid and inexact flags go out with the result. A typical use is argument reduction ahead of a periodic or logarithmic kernel: the caller keeps the integer-plus-M-bit part implicitly and works on the small remainder.

The control byte carries four things. It gives the number of fraction bits M to strip, and a rounding-mode field. A source bit chooses between that field and the external rounding-mode input. A suppress bit masks the inexact flag. The unit has one register stage. A result is presented one clock after the operand is accepted.

Top module: `fp32_frac_reduce`

## Requirements
- R1: `valid_o`, `res_o`, `invalid_o` and `inexact_o` are registered. They reflect an operand accepted with `valid_i` high on the next rising clock edge, and `valid_o` is low in the cycle after `valid_i` was low. While `rst_ni` is low all outputs are 0.
- R2: Control bits [7:4] give M (0..15), and bit [3] is the inexact-suppress bit. When bit [2] is 0 the mode comes from bits [1:0] and `ext_rm_i` has no effect. When bit [2] is 1 the mode comes from `ext_rm_i` and bits [1:0] have no effect. Mode codes: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R3: For a finite nonzero operand x, the result is x − R(2^M·x)·2^-M, where R rounds to an integer in the selected mode.
- R4: R follows the selected mode, and under nearest-even an exact half rounds to the even integer.
- R5: A NaN operand returns the same NaN with fraction bit 22 set. `invalid_o` is 1 only when bit 22 was 0 on input (signaling NaN).
- R6: `inexact_o` is 1 when the rounding step discards nonzero bits, unless control bit [3] is 1. NaN, infinity and zero operands never set it.
- R7: A zero operand is returned unchanged. An operand whose unbiased exponent is at least 23 − M, or any operand whose remainder is exactly zero, returns a zero carrying the operand's sign.
- R8: An infinite operand returns a zero of the operand's sign with no flags.
- R9: Subnormal operands are handled at full precision, with no flush to zero. Subnormal results are produced exactly.
- R10: The result magnitude is at most 2^-(M+1) under nearest-even and strictly below 2^-M under the other modes.
- R11: When the rounded integer is larger in magnitude than the operand, the subtraction result is itself rounded to single precision in the same mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand valid |
| src_i | input | 32 | Single-precision operand |
| ctrl_i | input | 8 | Cut count, suppress, mode source, mode field |
| ext_rm_i | input | 2 | External rounding mode |
| valid_o | output | 1 | Result valid |
| res_o | output | 32 | Single-precision remainder |
| invalid_o | output | 1 | Signaling NaN seen |
| inexact_o | output | 1 | Nonzero bits discarded |

## Verification
Operands with discarded bits above, below and exactly at the half point are run through all four modes and both signs. This separates nearest-even tie handling from the directed modes, and shows whether the remainder or its complement is returned. Pairs that differ only in the mode-source bit or in `ext_rm_i` show which mode field is honoured. Exponents on both sides of the 23 − M cut separate a zero result from a one-ulp remainder. Tiny subnormal operands under directed modes force a borrow across the full exponent range, and so exercise rounding of the subtraction itself. NaN, infinity and signed-zero operands check the special-value bypass and the flags.

// File: rtl/frr_pkg.sv
package frr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned EXP_W   = 8;
  localparam int unsigned MAN_W   = 23;
  localparam int unsigned SIG_W   = MAN_W + 1;
  localparam int unsigned BIAS    = 127;
  localparam int unsigned CUT_W   = 4;
  localparam int unsigned EXP_UW  = EXP_W + 3;
  localparam int unsigned WIN_W   = 2 * SIG_W + 3;
  localparam int unsigned KC_W    = $clog2(WIN_W);
  localparam int unsigned KQ_W    = $clog2(SIG_W + 2);
  localparam int unsigned ADJ_W   = EXP_W;
  localparam int unsigned WIDE_W  = 64;
  localparam int          EMIN    = 1 - int'(BIAS);
  localparam int          MIN_LSB = EMIN - int'(MAN_W);

  typedef enum logic [1:0] {
    RM_RNE = 2'b00,
    RM_RDN = 2'b01,
    RM_RUP = 2'b10,
    RM_RTZ = 2'b11
  } rmode_e;

  // bit layout matters: decoded straight from the control byte
  typedef struct packed {
    logic [CUT_W-1:0] cut;
    logic             spe;
    logic             use_ext;
    logic [1:0]       rm_field;
  } ctrl_t;

  typedef struct packed {
    logic              sign;
    logic              is_zero;
    logic              is_inf;
    logic              is_nan;
    logic              is_snan;
    logic [SIG_W-1:0]  sig;
    logic [EXP_UW-1:0] exp_u;
  } opnd_t;
endpackage

// File: rtl/frr_unpack.sv
module frr_unpack
  import frr_pkg::*;
(
  input  logic [WORD_W-1:0] src_i,
  output opnd_t             opnd_o
);
  logic [EXP_W-1:0] e_fld;
  logic [MAN_W-1:0] f_fld;
  logic             e_max;
  logic             e_min;

  always_comb begin
    e_fld = src_i[WORD_W-2 -: EXP_W];
    f_fld = src_i[MAN_W-1:0];
    e_max = (e_fld == '1);
    e_min = (e_fld == '0);
    opnd_o.sign    = src_i[WORD_W-1];
    opnd_o.is_zero = e_min && (f_fld == '0);
    opnd_o.is_inf  = e_max && (f_fld == '0);
    opnd_o.is_nan  = e_max && (f_fld != '0);
    opnd_o.is_snan = e_max && (f_fld != '0) && !f_fld[MAN_W-1];
    opnd_o.sig     = {!e_min, f_fld};
    opnd_o.exp_u   = e_min ? EXP_UW'(EMIN)
                           : EXP_UW'(e_fld) - EXP_UW'(BIAS);
  end
endmodule

// File: rtl/frr_split.sv
module frr_split
  import frr_pkg::*;
(
  input  logic              sign_i,
  input  logic [EXP_UW-1:0] exp_u_i,
  input  logic [SIG_W-1:0]  sig_i,
  input  logic [CUT_W-1:0]  cut_i,
  input  rmode_e            rm_i,
  output logic              all_int_o,
  output logic [SIG_W-1:0]  rem_o,
  output logic              rem_nz_o,
  output logic              up_o,
  output logic [KC_W-1:0]   kc_o,
  output logic [ADJ_W-1:0]  adj_o
);
  localparam int unsigned SX_W = SIG_W + 2;
  localparam logic signed [EXP_UW-1:0] KQ_CAP = EXP_UW'(SIG_W + 1);
  localparam logic signed [EXP_UW-1:0] KC_CAP = EXP_UW'(WIN_W - 1);

  logic signed [EXP_UW-1:0] k_s;
  logic [KQ_W-1:0]          kq;
  logic [SX_W-1:0]          sig_x, mask, rem_x, half;
  logic                     gt_half, eq_half, q_lsb;

  always_comb begin
    // k = number of significand bits that lie below the cut
    k_s       = $signed(EXP_UW'(MAN_W)) - $signed(exp_u_i) - $signed(EXP_UW'(cut_i));
    all_int_o = (k_s <= 0);
    kq        = (k_s > KQ_CAP) ? KQ_W'(SIG_W + 1) : KQ_W'(k_s);
    sig_x     = SX_W'(sig_i);
    mask      = (SX_W'(1) << kq) - SX_W'(1);
    rem_x     = sig_x & mask;
    half      = SX_W'(1) << (kq - KQ_W'(1));
    gt_half   = rem_x > half;
    eq_half   = rem_x == half;
    q_lsb     = sig_x[kq];
    rem_o     = rem_x[SIG_W-1:0];
    rem_nz_o  = (rem_x != '0);
    kc_o      = (k_s > KC_CAP) ? KC_W'(WIN_W - 1) : KC_W'(k_s);
    adj_o     = (k_s > KC_CAP) ? ADJ_W'(k_s - KC_CAP) : '0;
    unique case (rm_i)
      RM_RNE:  up_o = gt_half || (eq_half && q_lsb);
      RM_RDN:  up_o = sign_i && rem_nz_o;
      RM_RUP:  up_o = !sign_i && rem_nz_o;
      default: up_o = 1'b0;
    endcase
    if (all_int_o) up_o = 1'b0;
  end
endmodule

// File: rtl/frr_norm.sv
module frr_norm
  import frr_pkg::*;
(
  input  logic                     sign_i,
  input  logic [EXP_UW-1:0]        exp_u_i,
  input  logic [SIG_W-1:0]         rem_i,
  input  logic                     up_i,
  input  logic [KC_W-1:0]          kc_i,
  input  logic [ADJ_W-1:0]         adj_i,
  input  rmode_e                   rm_i,
  output logic                     sign_o,
  output logic [WORD_W-2:0]        mag_o,
  output logic                     inexact_o
);
  localparam logic signed [EXP_UW-1:0] FLOOR_E = EXP_UW'(MIN_LSB);

  logic [WIN_W-1:0]         diff;
  logic [KC_W-1:0]          lead;
  logic signed [EXP_UW-1:0] lsb_e, msb_e, tgt_e, sh;
  logic [KC_W-1:0]          rs, ls;
  logic [WIDE_W-1:0]        wide, kept_w, lost, half_bit;
  logic [SIG_W-1:0]         kept;
  logic                     guard, sticky, inc;
  logic [SIG_W:0]           sig_r;
  logic [EXP_W-1:0]         eb;

  always_comb begin
    // complement of the remainder when the integer part was rounded away from zero
    diff = up_i ? ((WIN_W'(1) << kc_i) - WIN_W'(rem_i)) : WIN_W'(rem_i);
    lead = '0;
    for (int i = 0; i < WIN_W; i++) begin
      if (diff[i]) lead = KC_W'(i);
    end
    lsb_e = $signed(exp_u_i) - $signed(EXP_UW'(MAN_W))
          + (up_i ? $signed(EXP_UW'(adj_i)) : $signed(EXP_UW'(0)));
    msb_e = lsb_e + $signed(EXP_UW'(lead));
    tgt_e = msb_e - $signed(EXP_UW'(MAN_W));
    if (tgt_e < FLOOR_E) tgt_e = FLOOR_E;
    sh = tgt_e - lsb_e;
    rs = (sh > 0) ? KC_W'(sh) : '0;
    ls = (sh < 0) ? KC_W'(-sh) : '0;
    wide     = WIDE_W'(diff) << ls;
    kept_w   = wide >> rs;
    half_bit = (rs != '0) ? (WIDE_W'(1) << (rs - KC_W'(1))) : '0;
    lost     = wide & ((WIDE_W'(1) << rs) - WIDE_W'(1));
    guard    = |(wide & half_bit);
    sticky   = |(lost & ~half_bit);
    kept     = kept_w[SIG_W-1:0];
    sign_o   = sign_i ^ up_i;
    unique case (rm_i)
      RM_RNE:  inc = guard && (sticky || kept[0]);
      RM_RDN:  inc = sign_o && (guard || sticky);
      RM_RUP:  inc = !sign_o && (guard || sticky);
      default: inc = 1'b0;
    endcase
    sig_r = {1'b0, kept} + (SIG_W + 1)'(inc);
    eb    = kept[SIG_W-1] ? EXP_W'(tgt_e + $signed(EXP_UW'(BIAS + MAN_W))) : '0;
    mag_o = sig_r[SIG_W] ? {eb + EXP_W'(1), {MAN_W{1'b0}}}
                         : {eb, sig_r[MAN_W-1:0]};
    inexact_o = guard || sticky;
  end
endmodule

// File: rtl/fp32_frac_reduce.sv
module fp32_frac_reduce
  import frr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] src_i,
  input  logic [7:0]  ctrl_i,
  input  logic [1:0]  ext_rm_i,
  output logic        valid_o,
  output logic [31:0] res_o,
  output logic        invalid_o,
  output logic        inexact_o
);
  localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (MAN_W - 1);

  ctrl_t             cfg;
  rmode_e            rm;
  opnd_t             op;
  logic              all_int, rem_nz, up;
  logic [SIG_W-1:0]  rem;
  logic [KC_W-1:0]   kc;
  logic [ADJ_W-1:0]  adj;
  logic              n_sign, n_inexact;
  logic [WORD_W-2:0] n_mag;
  logic [WORD_W-1:0] res_d;
  logic              inv_d, inx_d;

  assign cfg = ctrl_t'(ctrl_i);
  assign rm  = cfg.use_ext ? rmode_e'(ext_rm_i) : rmode_e'(cfg.rm_field);

  frr_unpack u_unpack (
    .src_i  (src_i),
    .opnd_o (op)
  );

  frr_split u_split (
    .sign_i    (op.sign),
    .exp_u_i   (op.exp_u),
    .sig_i     (op.sig),
    .cut_i     (cfg.cut),
    .rm_i      (rm),
    .all_int_o (all_int),
    .rem_o     (rem),
    .rem_nz_o  (rem_nz),
    .up_o      (up),
    .kc_o      (kc),
    .adj_o     (adj)
  );

  frr_norm u_norm (
    .sign_i    (op.sign),
    .exp_u_i   (op.exp_u),
    .rem_i     (rem),
    .up_i      (up),
    .kc_i      (kc),
    .adj_i     (adj),
    .rm_i      (rm),
    .sign_o    (n_sign),
    .mag_o     (n_mag),
    .inexact_o (n_inexact)
  );

  always_comb begin
    res_d = '0;
    inv_d = 1'b0;
    inx_d = 1'b0;
    if (op.is_nan) begin
      res_d = src_i | QUIET_BIT;
      inv_d = op.is_snan;
    end else if (op.is_inf) begin
      res_d = {op.sign, {(WORD_W-1){1'b0}}};
    end else if (op.is_zero) begin
      res_d = src_i;
    end else if (all_int || !rem_nz) begin
      res_d = {op.sign, {(WORD_W-1){1'b0}}};
    end else begin
      res_d = {n_sign, n_mag};
      inx_d = !cfg.spe && (rem_nz || n_inexact);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      res_o     <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o     <= res_d;
        invalid_o <= inv_d;
        inexact_o <= inx_d;
      end
    end
  end
endmodule

// File: rtl/frr_chk.sv
module frr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] src_i,
  input logic [7:0]  ctrl_i,
  input logic [1:0]  ext_rm_i,
  input logic        valid_o,
  input logic [31:0] res_o,
  input logic        invalid_o,
  input logic        inexact_o
);
  logic       nan_in, snan_in, inf_in, zero_in;
  logic [1:0] rm_in;

  assign nan_in  = (src_i[30:23] == 8'hFF) && (src_i[22:0] != '0);
  assign snan_in = nan_in && !src_i[22];
  assign inf_in  = (src_i[30:23] == 8'hFF) && (src_i[22:0] == '0);
  assign zero_in = (src_i[30:0] == '0);
  assign rm_in   = ctrl_i[2] ? ext_rm_i : ctrl_i[1:0];

  AST_VALID_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_IDLE_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R1
  AST_NAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && nan_in) |=> (res_o == ($past(src_i) | 32'h0040_0000))); // R5
  AST_SNAN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (invalid_o == $past(snan_in))); // R5
  AST_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i[3]) |=> !inexact_o); // R6
  AST_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && zero_in) |=> (res_o == $past(src_i)) && !inexact_o); // R7
  AST_INF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && inf_in) |=> (res_o == {$past(src_i[31]), 31'd0}) && !inexact_o); // R8
  AST_RNE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !nan_in && rm_in == 2'b00)
      |=> (res_o[30:0] <= {8'd126 - {4'd0, $past(ctrl_i[7:4])}, 23'd0})); // R10
  AST_DIR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !nan_in && rm_in != 2'b00)
      |=> (res_o[30:0] < {8'd127 - {4'd0, $past(ctrl_i[7:4])}, 23'd0})); // R10
endmodule

bind fp32_frac_reduce frr_chk u_chk (.*);

// File: tb/sim_fp32_frac_reduce.sv
`timescale 1ns/1ps
module sim_fp32_frac_reduce;
  // Infinite operands are defined to return a zero of the operand's sign (R8).
  // An exact-zero remainder keeps the operand's sign in every mode (R7).
  typedef struct packed {
    logic [31:0] src;
    logic [7:0]  ctrl;
    logic [1:0]  ext;
    logic [31:0] res;
    logic        inv;
    logic        inx;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{32'h3FE00000, 8'h00, 2'd0, 32'hBE800000, 1'b0, 1'b1, "R3 "}, // 1.75 -> -0.25
    '{32'h3FE00000, 8'h10, 2'd0, 32'hBE800000, 1'b0, 1'b1, "R4 "}, // 3.5 ties to 4
    '{32'h40200000, 8'h00, 2'd0, 32'h3F000000, 1'b0, 1'b1, "R4 "}, // 2.5 ties to 2
    '{32'h40200000, 8'h02, 2'd0, 32'hBF000000, 1'b0, 1'b1, "R4 "}, // up -> 3
    '{32'hC0200000, 8'h01, 2'd0, 32'h3F000000, 1'b0, 1'b1, "R4 "}, // down -> -3
    '{32'hC0200000, 8'h03, 2'd0, 32'hBF000000, 1'b0, 1'b1, "R4 "}, // zero -> -2
    '{32'h40200000, 8'h06, 2'd3, 32'h3F000000, 1'b0, 1'b1, "R2 "}, // external mode wins
    '{32'h40200000, 8'h02, 2'd3, 32'hBF000000, 1'b0, 1'b1, "R2 "}, // external ignored
    '{32'h3FE00000, 8'h08, 2'd0, 32'hBE800000, 1'b0, 1'b0, "R6 "}, // suppressed
    '{32'h3FE00000, 8'h0C, 2'd0, 32'hBE800000, 1'b0, 1'b0, "R6 "},
    '{32'h40400000, 8'h00, 2'd0, 32'h00000000, 1'b0, 1'b0, "R7 "}, // 3.0 exact
    '{32'hCB000000, 8'h00, 2'd0, 32'h80000000, 1'b0, 1'b0, "R7 "}, // -2^23
    '{32'h43800001, 8'hF0, 2'd0, 32'h00000000, 1'b0, 1'b0, "R7 "}, // exponent at cut
    '{32'h43000001, 8'hF0, 2'd0, 32'h37800000, 1'b0, 1'b1, "R10"}, // one below cut
    '{32'h7FC00001, 8'h00, 2'd0, 32'h7FC00001, 1'b0, 1'b0, "R5 "},
    '{32'h7F800001, 8'h00, 2'd0, 32'h7FC00001, 1'b1, 1'b0, "R5 "},
    '{32'hFF800005, 8'h08, 2'd0, 32'hFFC00005, 1'b1, 1'b0, "R5 "},
    '{32'h7F800000, 8'h00, 2'd0, 32'h00000000, 1'b0, 1'b0, "R8 "},
    '{32'hFF800000, 8'h02, 2'd0, 32'h80000000, 1'b0, 1'b0, "R8 "},
    '{32'h80000000, 8'h00, 2'd0, 32'h80000000, 1'b0, 1'b0, "R7 "},
    '{32'h00000003, 8'h00, 2'd0, 32'h00000003, 1'b0, 1'b1, "R9 "}, // subnormal kept
    '{32'h00000003, 8'h02, 2'd0, 32'hBF7FFFFF, 1'b0, 1'b1, "R11"}, // tiny - 1
    '{32'h80000003, 8'h01, 2'd0, 32'h3F7FFFFF, 1'b0, 1'b1, "R11"}, // 1 - tiny
    '{32'h3F840000, 8'h40, 2'd0, 32'h3D000000, 1'b0, 1'b1, "R3 "}, // M=4 tie even
    '{32'h3F840000, 8'h42, 2'd0, 32'hBD000000, 1'b0, 1'b1, "R3 "}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] src_i = '0;
  logic [7:0]  ctrl_i = '0;
  logic [1:0]  ext_rm_i = '0;
  logic        valid_o, invalid_o, inexact_o;
  logic [31:0] res_o;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  fp32_frac_reduce u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .src_i     (src_i),
    .ctrl_i    (ctrl_i),
    .ext_rm_i  (ext_rm_i),
    .valid_o   (valid_o),
    .res_o     (res_o),
    .invalid_o (invalid_o),
    .inexact_o (inexact_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs at zero even with a valid operand present
    valid_i = 1'b1; src_i = 32'h3FE00000;
    repeat (3) @(negedge clk);
    chk("R1", "reset valid", 32'(valid_o), 32'd0);
    chk("R1", "reset res", res_o, 32'd0);
    chk("R1", "reset flags", {30'd0, invalid_o, inexact_o}, 32'd0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "idle valid", 32'(valid_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      valid_i  = 1'b1;
      src_i    = VECS[i].src;
      ctrl_i   = VECS[i].ctrl;
      ext_rm_i = VECS[i].ext;
      @(negedge clk);
      chk("R1", "valid", 32'(valid_o), 32'd1);
      chk(string'(VECS[i].tag), "res", res_o, VECS[i].res);
      chk(string'(VECS[i].tag), "invalid", 32'(invalid_o), 32'(VECS[i].inv));
      chk(string'(VECS[i].tag), "inexact", 32'(inexact_o), 32'(VECS[i].inx));
    end

    // R1: a gap in valid_i drops valid_o one cycle later
    valid_i = 1'b0;
    src_i   = 32'h40200000;
    @(negedge clk);
    chk("R1", "gap valid", 32'(valid_o), 32'd0);

    // R2: same operand, mode source flipped back and forth across adjacent cycles
    valid_i = 1'b1; src_i = 32'h40200000; ctrl_i = 8'h04; ext_rm_i = 2'd2;
    @(negedge clk);
    chk("R2", "ext up", res_o, 32'hBF000000);
    ctrl_i = 8'h00; ext_rm_i = 2'd2;
    @(negedge clk);
    chk("R2", "field rne", res_o, 32'h3F000000);

    // R6: identical inexact case with and without suppression
    src_i = 32'h00000003; ctrl_i = 8'h0A; ext_rm_i = 2'd0;
    @(negedge clk);
    chk("R6", "spe tiny", res_o, 32'hBF7FFFFF);
    chk("R6", "spe flag", 32'(inexact_o), 32'd0);

    // R10: largest RNE remainder at M=0 is exactly one half
    src_i = 32'h3FC00000; ctrl_i = 8'h00;
    @(negedge clk);
    chk("R10", "half bound", res_o, 32'hBF000000);

    valid_i = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule